// File: doc/BRIEF.md
# Half-Duplex Shared-Bus Data Port

This block is the digital edge of a converter front end whose transmit and receive paths share a single 10-bit data bus. Two enable inputs from the host decide who owns the bus. The transmit enable opens the capture of bus words into the transmit path. The receive enable turns on the pad drivers and puts receive samples on the bus. When both are inactive, the port neither captures nor drives, so it can sit on a bus that other devices share.

Each direction has its own external clock. A five-entry elastic FIFO carries data between that clock and the internal sample clock, which runs at the same frequency with any phase. The pad side is split into separate input, output and output-enable signals. The enable polarity, the active clock edge and the data format are set per direction through plain configuration inputs. Two further inputs force the driver off and select reduced drive strength. After the host stops sending, the transmit path is fed 33 zero words so that downstream filters drain.

Top module: `shared_bus_port`

## Requirements
- R1: Out of reset, and with both enables inactive, `pad_oe` is 0, `pad_out` is 0, `dac_valid` is 0 and no bus word is captured.
- R2: A bus word is captured on a transmit edge when the transmit enable is active and the receive enable is inactive. With all clocks aligned, it appears on `dac_word` with `dac_valid` high after the second sample-clock edge that follows the capturing edge.
- R3: `pad_oe` follows the receive enable without a clock edge, turning on and off at once. `pad_out` is 0 whenever `pad_oe` is 0.
- R4: From the receive enable becoming active, the driven bus carries 0 after receive edges 1 to 5. It carries receive samples from edge 6 on.
- R5: While the receive enable is active, no bus word enters the transmit path, even if the transmit enable is active at the same time.
- R6: After the last capturing edge, the next 33 transmit edges each write a valid zero word, whatever is on the bus. The transmit path then writes invalid entries, so `dac_valid` falls.
- R7: `cfg_tx_inv` and `cfg_rx_inv` make the matching enable active low. One control line can then drive both enables, giving receive on high and transmit on low.
- R8: `cfg_tx_fall` moves bus capture to the falling edge of `txclk`. `cfg_rx_fall` moves bus updates to the falling edge of `rxclk`.
- R9: With `cfg_tx_twos` set, the MSB (bit 9) of each captured word is inverted. With `cfg_rx_twos` set, bit 9 of each valid receive word is inverted before it is driven. The zero prefix is not affected.
- R10: `cfg_rx_hiz` holds `pad_oe` at 0 and `pad_out` at 0 even while the receive enable is active.
- R11: `pad_low_drive` reflects `cfg_low_drive`.
- R12: Receive samples reach the bus in order and without gaps. With clocks aligned, a sample taken on a sample-clock edge is driven after the second receive edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Internal sample clock |
| txclk | input | 1 | External transmit clock |
| rxclk | input | 1 | External receive clock |
| tx_enable_in | input | 1 | Transmit enable from host |
| rx_enable_in | input | 1 | Receive enable from host |
| cfg_tx_inv | input | 1 | Transmit enable active low |
| cfg_tx_fall | input | 1 | Capture on falling transmit edge |
| cfg_tx_twos | input | 1 | Transmit words in twos complement |
| cfg_rx_inv | input | 1 | Receive enable active low |
| cfg_rx_fall | input | 1 | Launch on falling receive edge |
| cfg_rx_twos | input | 1 | Receive words in twos complement |
| cfg_rx_hiz | input | 1 | Force receive driver off |
| cfg_low_drive | input | 1 | Reduced drive strength request |
| pad_in | input | 10 | Bus value seen at the pads |
| adc_word | input | 10 | Receive sample, sample-clock domain |
| pad_out | output | 10 | Value driven toward the pads |
| pad_oe | output | 1 | Pad output enable |
| pad_low_drive | output | 1 | Drive strength select to the pads |
| dac_word | output | 10 | Transmit sample, sample-clock domain |
| dac_valid | output | 1 | Transmit sample carries data or flush zero |

## Verification
The bench ties all three clocks to one source, so every latency is a fixed count of rising edges. It drives inputs 1 ns after an edge and samples 1 ns after a later edge. On that basis, a bus word set at step i is on `dac_word` at step i+3, and an `adc_word` set at step i is on `pad_out` at step i+3. Receive data follows six edges after the enable, and flush zeros are counted over the 33 edges after the enable drops. `pad_oe` is combinational, so it is checked 1 ns after the enable changes, with no edge in between. The falling-edge options are checked by changing the bus value or reading the bus at each half period.

// File: rtl/shfp_pkg.sv
`timescale 1ns/1ps
package shfp_pkg;
  localparam int BUS_W      = 10;
  localparam int FIFO_DEPTH = 5;
  localparam int FIFO_LAG   = 2;
  localparam int RX_LAT     = 6;
  localparam int FLUSH_LEN  = 33;
endpackage

// File: rtl/shfp_phase_fifo.sv
`timescale 1ns/1ps
module shfp_phase_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 5,
  parameter int LAG   = 2
) (
  input  logic         rst_n,
  input  logic         wclk,
  input  logic         rclk,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
  localparam logic [PW-1:0] RSTRT = PW'(DEPTH - LAG);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  function automatic logic [PW-1:0] ring_next(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      mem[wptr] <= wdata;
      wptr      <= ring_next(wptr);
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= RSTRT;
      rdata <= '0;
    end else begin
      rdata <= mem[rptr];
      rptr  <= ring_next(rptr);
    end
  end
endmodule

// File: rtl/shfp_tx_front.sv
`timescale 1ns/1ps
module shfp_tx_front #(
  parameter int W     = 10,
  parameter int FLUSH = 33
) (
  input  logic         rst_n,
  input  logic         eclk,
  input  logic         tx_act,
  input  logic         rx_act,
  input  logic         twos,
  input  logic [W-1:0] pad_in,
  output logic         cap_fire,
  output logic [$clog2(FLUSH+1)-1:0] flush_cnt,
  output logic [W:0]   wword
);
  localparam int FW = $clog2(FLUSH + 1);

  function automatic logic [W-1:0] to_offset(input logic [W-1:0] d, input logic tc);
    return tc ? {~d[W-1], d[W-2:0]} : d;
  endfunction

  logic flushing;

  assign cap_fire = tx_act & ~rx_act;
  assign flushing = (flush_cnt != '0);
  assign wword    = cap_fire ? {1'b1, to_offset(pad_in, twos)}
                             : {flushing, {W{1'b0}}};

  always_ff @(posedge eclk or negedge rst_n) begin
    if (!rst_n)        flush_cnt <= '0;
    else if (cap_fire) flush_cnt <= FW'(FLUSH);
    else if (flushing) flush_cnt <= flush_cnt - 1'b1;
  end
endmodule

// File: rtl/shfp_rx_back.sv
`timescale 1ns/1ps
module shfp_rx_back #(
  parameter int W   = 10,
  parameter int LAT = 6
) (
  input  logic         rst_n,
  input  logic         eclk,
  input  logic         rx_act,
  input  logic         hiz,
  input  logic         twos,
  input  logic [W-1:0] fifo_word,
  output logic [$clog2(LAT+1)-1:0] lat_cnt,
  output logic         pad_oe,
  output logic [W-1:0] pad_out
);
  localparam int CW = $clog2(LAT + 1);

  function automatic logic [W-1:0] from_offset(input logic [W-1:0] d, input logic tc);
    return tc ? {~d[W-1], d[W-2:0]} : d;
  endfunction

  logic ready;

  assign ready   = (lat_cnt == CW'(LAT));
  assign pad_oe  = rx_act & ~hiz;
  assign pad_out = (pad_oe && ready) ? from_offset(fifo_word, twos) : '0;

  always_ff @(posedge eclk or negedge rst_n) begin
    if (!rst_n)      lat_cnt <= '0;
    else if (!rx_act) lat_cnt <= '0;
    else if (!ready) lat_cnt <= lat_cnt + 1'b1;
  end
endmodule

// File: rtl/shared_bus_port.sv
`timescale 1ns/1ps
module shared_bus_port #(
  parameter int W     = shfp_pkg::BUS_W,
  parameter int DEPTH = shfp_pkg::FIFO_DEPTH,
  parameter int LAG   = shfp_pkg::FIFO_LAG,
  parameter int LAT   = shfp_pkg::RX_LAT,
  parameter int FLUSH = shfp_pkg::FLUSH_LEN
) (
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         txclk,
  input  logic         rxclk,
  input  logic         tx_enable_in,
  input  logic         rx_enable_in,
  input  logic         cfg_tx_inv,
  input  logic         cfg_tx_fall,
  input  logic         cfg_tx_twos,
  input  logic         cfg_rx_inv,
  input  logic         cfg_rx_fall,
  input  logic         cfg_rx_twos,
  input  logic         cfg_rx_hiz,
  input  logic         cfg_low_drive,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] adc_word,
  output logic [W-1:0] pad_out,
  output logic         pad_oe,
  output logic         pad_low_drive,
  output logic [W-1:0] dac_word,
  output logic         dac_valid
);
  localparam int FW = $clog2(FLUSH + 1);
  localparam int CW = $clog2(LAT + 1);

  // Named internal events, also watched by the checker
  logic          tx_eclk, rx_eclk;
  logic          tx_act, rx_act;
  logic          cap_fire;
  logic [FW-1:0] flush_cnt;
  logic [CW-1:0] lat_cnt;
  logic [W:0]    tx_wword, tx_rword;
  logic [W-1:0]  rx_rword;

  assign tx_eclk       = txclk ^ cfg_tx_fall;
  assign rx_eclk       = rxclk ^ cfg_rx_fall;
  assign tx_act        = tx_enable_in ^ cfg_tx_inv;
  assign rx_act        = rx_enable_in ^ cfg_rx_inv;
  assign pad_low_drive = cfg_low_drive;

  shfp_tx_front #(.W(W), .FLUSH(FLUSH)) u_txf (
    .rst_n(rst_n), .eclk(tx_eclk), .tx_act(tx_act), .rx_act(rx_act),
    .twos(cfg_tx_twos), .pad_in(pad_in), .cap_fire(cap_fire),
    .flush_cnt(flush_cnt), .wword(tx_wword)
  );

  shfp_phase_fifo #(.W(W + 1), .DEPTH(DEPTH), .LAG(LAG)) u_txq (
    .rst_n(rst_n), .wclk(tx_eclk), .rclk(sclk),
    .wdata(tx_wword), .rdata(tx_rword)
  );

  assign dac_valid = tx_rword[W];
  assign dac_word  = tx_rword[W-1:0];

  shfp_phase_fifo #(.W(W), .DEPTH(DEPTH), .LAG(LAG)) u_rxq (
    .rst_n(rst_n), .wclk(sclk), .rclk(rx_eclk),
    .wdata(adc_word), .rdata(rx_rword)
  );

  shfp_rx_back #(.W(W), .LAT(LAT)) u_rxb (
    .rst_n(rst_n), .eclk(rx_eclk), .rx_act(rx_act), .hiz(cfg_rx_hiz),
    .twos(cfg_rx_twos), .fifo_word(rx_rword), .lat_cnt(lat_cnt),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );
endmodule

// File: rtl/shared_bus_port_chk.sv
`timescale 1ns/1ps
module shared_bus_port_chk #(
  parameter int W     = 10,
  parameter int LAT   = 6,
  parameter int FLUSH = 33
) (
  input logic                       rst_n,
  input logic                       sclk,
  input logic                       tx_eclk,
  input logic                       rx_eclk,
  input logic                       rx_act,
  input logic                       cap_fire,
  input logic [$clog2(FLUSH+1)-1:0] flush_cnt,
  input logic [$clog2(LAT+1)-1:0]   lat_cnt,
  input logic                       pad_oe,
  input logic [W-1:0]               pad_out,
  input logic                       cfg_rx_hiz
);
  localparam int CW = $clog2(LAT + 1);
  localparam int FW = $clog2(FLUSH + 1);

  p_no_loopback_r5: assert property (@(posedge tx_eclk) disable iff (!rst_n)
    rx_act |-> !cap_fire);

  p_quiet_undriven_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    !pad_oe |-> pad_out == '0);

  p_forced_hiz_r10: assert property (@(posedge sclk) disable iff (!rst_n)
    cfg_rx_hiz |-> !pad_oe);

  p_zero_prefix_r4: assert property (@(posedge rx_eclk) disable iff (!rst_n)
    (pad_oe && lat_cnt != CW'(LAT)) |-> pad_out == '0);

  p_latency_step_r4: assert property (@(posedge rx_eclk) disable iff (!rst_n)
    (rx_act && lat_cnt != CW'(LAT)) |=> (!rx_act || lat_cnt == CW'($past(lat_cnt) + 1'b1)) || !$past(rx_act));

  p_flush_countdown_r6: assert property (@(posedge tx_eclk) disable iff (!rst_n)
    (!cap_fire && flush_cnt != '0) |=> flush_cnt == FW'($past(flush_cnt) - 1'b1));
endmodule

bind shared_bus_port shared_bus_port_chk #(.W(W), .LAT(LAT), .FLUSH(FLUSH)) u_chk (
  .rst_n(rst_n), .sclk(sclk), .tx_eclk(tx_eclk), .rx_eclk(rx_eclk),
  .rx_act(rx_act), .cap_fire(cap_fire), .flush_cnt(flush_cnt),
  .lat_cnt(lat_cnt), .pad_oe(pad_oe), .pad_out(pad_out),
  .cfg_rx_hiz(cfg_rx_hiz)
);

// File: tb/shared_bus_port_test.sv
`timescale 1ns/1ps
module shared_bus_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, rx_en = 1'b0;
  logic [7:0] cfg = '0;
  logic [9:0] pad_in = '0, adc_word = '0;
  logic [9:0] pad_out, dac_word;
  logic       pad_oe, pad_low_drive, dac_valid;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // cfg bits: 0 tx_inv, 1 tx_fall, 2 tx_twos, 3 rx_inv, 4 rx_fall, 5 rx_twos, 6 rx_hiz, 7 low_drive
  shared_bus_port uut (
    .rst_n(rst_n), .sclk(clk), .txclk(clk), .rxclk(clk),
    .tx_enable_in(tx_en), .rx_enable_in(rx_en),
    .cfg_tx_inv(cfg[0]), .cfg_tx_fall(cfg[1]), .cfg_tx_twos(cfg[2]),
    .cfg_rx_inv(cfg[3]), .cfg_rx_fall(cfg[4]), .cfg_rx_twos(cfg[5]),
    .cfg_rx_hiz(cfg[6]), .cfg_low_drive(cfg[7]),
    .pad_in(pad_in), .adc_word(adc_word),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_low_drive(pad_low_drive),
    .dac_word(dac_word), .dac_valid(dac_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic reset_dut(input logic [7:0] c);
    rst_n = 1'b0; tx_en = 1'b0; rx_en = 1'b0; pad_in = '0;
    #1 cfg = c;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  task automatic t_reset_idle();
    int seen = 0;
    reset_dut(8'h00);
    chk("R1 reset pad_oe", pad_oe, 0);
    chk("R1 reset pad_out", pad_out, 0);
    chk("R1 reset dac_valid", dac_valid, 0);
    for (int i = 0; i < 8; i++) begin
      pad_in = 10'(37 * i + 5);
      step();
      seen += (dac_valid | pad_oe) ? 1 : 0;
    end
    chk("R1 idle no capture or drive", seen, 0);
  endtask

  task automatic t_tx_capture_flush(input logic twos);
    int zeros = 0, late = 0;
    logic [9:0] d [12];
    reset_dut({5'b0, twos, 2'b00});
    tx_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      d[i] = 10'(10'h100 + 53 * i);
      if (i >= 3) begin
        chk(twos ? "R9 tx twos valid" : "R2 tx valid", dac_valid, 1);
        chk(twos ? "R9 tx twos word" : "R2 tx word", dac_word, twos ? (d[i-3] ^ 10'h200) : d[i-3]);
      end else chk("R2 tx pipeline empty", dac_valid, 0);
      pad_in = d[i];
      step();
    end
    tx_en = 1'b0;
    pad_in = 10'h3FF;
    for (int m = 1; m <= 40; m++) begin
      step();
      if (m == 2) chk("R2 last word", dac_word, twos ? (d[11] ^ 10'h200) : d[11]);
      if (m >= 3 && dac_valid && dac_word == 0) zeros++;
      if (m >= 36 && dac_valid) late++;
    end
    chk("R6 flush zero count", zeros, 33);
    chk("R6 valid falls after flush", late, 0);
  endtask

  task automatic t_rx_latency(input logic twos);
    reset_dut({2'b00, twos, 5'b0});
    adc_word = 10'h155;
    repeat (6) step();
    rx_en = 1'b1;
    #1;
    chk("R3 oe on without edge", pad_oe, 1);
    chk("R4 zero at enable", pad_out, 0);
    for (int e = 1; e <= 6; e++) begin
      step();
      chk(e < 6 ? "R4 zero prefix" : (twos ? "R9 rx twos data" : "R4 data at edge 6"),
          pad_out, e < 6 ? 10'h000 : (twos ? 10'h355 : 10'h155));
    end
    rx_en = 1'b0;
    #1;
    chk("R3 oe off without edge", pad_oe, 0);
    chk("R3 out zero when off", pad_out, 0);
  endtask

  task automatic t_rx_stream();
    int bad = 0;
    reset_dut(8'h00);
    rx_en = 1'b1;
    for (int i = 0; i < 24; i++) begin
      if (i >= 10 && pad_out !== 10'(100 + i - 3)) bad++;
      adc_word = 10'(100 + i);
      step();
    end
    chk("R12 ordered stream mismatches", bad, 0);
    rx_en = 1'b0;
  endtask

  task automatic t_loopback();
    int hits = 0;
    reset_dut(8'h00);
    rx_en = 1'b1; tx_en = 1'b1; pad_in = 10'h2AA;
    for (int i = 0; i < 12; i++) begin
      step();
      hits += dac_valid ? 1 : 0;
    end
    chk("R5 bus driven", pad_oe, 1);
    chk("R5 nothing captured", hits, 0);
  endtask

  task automatic t_shared_line();
    int hits = 0;
    reset_dut(8'h01);
    adc_word = 10'h0F0;
    tx_en = 1'b1; rx_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step();
      hits += dac_valid ? 1 : 0;
    end
    chk("R7 rx active on high line", pad_oe, 1);
    chk("R7 rx data", pad_out, 10'h0F0);
    chk("R7 tx inactive on high line", hits, 0);
    tx_en = 1'b0; rx_en = 1'b0; pad_in = 10'h123;
    #1;
    chk("R7 low line releases bus", pad_oe, 0);
    repeat (3) step();
    chk("R7 tx active on low line", dac_valid, 1);
    chk("R7 tx word", dac_word, 10'h123);
    cfg[6] = 1'b1;
    tx_en = 1'b1; rx_en = 1'b1;
    #1;
    chk("R10 forced hiz oe", pad_oe, 0);
    repeat (8) step();
    chk("R10 forced hiz oe later", pad_oe, 0);
    chk("R10 forced hiz out", pad_out, 0);
  endtask

  task automatic t_tx_fall();
    int bad = 0;
    reset_dut(8'h02);
    tx_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      step();
      if (i >= 5 && !(dac_valid && dac_word >= 10'h0A0 && dac_word < 10'h0B0)) bad++;
      pad_in = 10'(10'h0A0 + i);
      #2.5 pad_in = 10'(10'h050 + i);
    end
    chk("R8 tx falling-edge capture", bad, 0);
    tx_en = 1'b0;
  endtask

  task automatic t_rx_fall();
    logic [9:0] v1, v2, v3;
    reset_dut(8'h10);
    rx_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      adc_word = 10'(200 + i);
      step();
    end
    v1 = pad_out;
    #1 v2 = pad_out;
    #1 v3 = pad_out;
    chk("R8 rx stable across rising edge", v2, v1);
    chk("R8 rx updates on falling edge", v3, 10'(v2 + 1));
    rx_en = 1'b0;
  endtask

  task automatic t_low_drive();
    reset_dut(8'h80);
    chk("R11 low drive status", pad_low_drive, 1);
  endtask

  initial begin
    t_reset_idle();
    t_tx_capture_flush(1'b0);
    t_tx_capture_flush(1'b1);
    t_rx_latency(1'b0);
    t_rx_latency(1'b1);
    t_rx_stream();
    t_loopback();
    t_shared_line();
    t_tx_fall();
    t_rx_fall();
    t_low_drive();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule